// File: doc/BRIEF.md
# Write-Back Snooping Invalidation Cache Controller

This block is the coherence controller of one processor's private data cache in a small shared-memory multiprocessor. The cache is direct-mapped and write-back. It keeps every line in one of three states: Invalid, Shared (clean and read-only) or Exclusive (the only copy, writable and dirty). The processor side issues single-word reads and writes. The block serves hits locally and turns every miss into a transaction on a shared, atomic, serialized bus. Because a cache must own the bus before a write can complete, the order of transactions on the bus fixes the global order of writes.

The controller watches the misses that other masters place on the bus. When another master's miss targets a block this cache holds dirty, the controller supplies the block from its own copy and raises a signal that tells memory to abort its response. The same signal pair marks the block as written back to memory. When a miss has to evict a dirty line, the victim goes into a one-entry write-back buffer. The new miss is issued first and the victim write-back follows. A snooped miss to the buffered block is answered from the buffer, and that answer cancels the pending write-back.

Top module: `snoop_cache`

## Requirements
- R1: After reset every line is Invalid and the buffer is empty. `cpuReady` is 1, and `cpuDone`, `busReq` and `intvValid` are 0. The first access to any address produces a bus miss.
- R2: A read to a line that is Invalid, or that holds another tag, issues a read miss (`busCmd` = 2'b01) for block address `cpuAddr >> 2`. The line enters Shared, even with no other sharer, and `cpuRdata` returns the fetched word at offset `cpuAddr[1:0]`.
- R3: A write to an Invalid line or a Shared line issues a write miss (`busCmd` = 2'b10), even when the tag matches. The processor word is merged into the fetched block at offset `cpuAddr[1:0]`, and the line becomes Exclusive.
- R4: Read hits in Shared or Exclusive, and write hits in Exclusive, raise `cpuDone` one cycle after acceptance and cause no bus request. `cpuRdata` carries the read word, or the written word on a write.
- R5: A snooped write miss (`snpCmd` = 2'b10) to a Shared line makes it Invalid, with no intervention. A snooped write-back (2'b11) changes nothing.
- R6: A snooped read miss (`snpCmd` = 2'b01) to an Exclusive line raises `intvValid` and `memAbort` in the same cycle, with the whole block on `intvData`. The line becomes Shared.
- R7: A snooped write miss to an Exclusive line raises `intvValid` and `memAbort` with the block, and the line becomes Invalid.
- R8: A miss that evicts an Exclusive line with another tag issues its own miss first. A write-back (`busCmd` = 2'b11) follows, carrying the victim's block address and data.
- R9: A snooped read or write miss to the block in the write-back buffer is answered from the buffer with `intvValid` and `memAbort`, and the pending write-back is dropped.
- R10: `cpuReady` is 0 in any cycle with `snpValid` and while a miss or write-back is in progress.
- R11: `busCmd` is 2'b00 unless `busGnt` is 1. Once raised for a transaction, `busReq` stays high until `busAck`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | Processor request, taken when `cpuReady` is 1 |
| cpuWrite | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | ADDR_W | Word address |
| cpuWdata | input | DATA_W | Write word |
| cpuReady | output | 1 | Controller can accept a request this cycle |
| cpuDone | output | 1 | One-cycle completion pulse |
| cpuRdata | output | DATA_W | Result word, valid with `cpuDone` |
| busReq | output | 1 | Bus request |
| busGnt | input | 1 | Bus grant |
| busCmd | output | 2 | 00 none, 01 read miss, 10 write miss, 11 write-back |
| busAddr | output | ADDR_W-log2(WORDS) | Block address |
| busWdata | output | WORDS*DATA_W | Write-back block, word w at bits w*DATA_W |
| busAck | input | 1 | Transaction complete; `busRdata` valid for misses |
| busRdata | input | WORDS*DATA_W | Fill block |
| snpValid | input | 1 | Another master's transaction is visible |
| snpCmd | input | 2 | Snooped command, same encoding as `busCmd` |
| snpAddr | input | ADDR_W-log2(WORDS) | Snooped block address |
| intvValid | output | 1 | This cache supplies the snooped block |
| intvData | output | WORDS*DATA_W | Supplied dirty block |
| memAbort | output | 1 | Memory must abort its response |

## Verification
The bench builds the block with its defaults: 8 lines of 4 words and 32-bit word addresses. With these values, addresses 0x204 and 0x404 share index 1, and 0x208 and 0x408 share index 2. That makes dirty eviction, buffered write-back and intervention from the buffer easy to reach. The bench also holds the bus grant back from the write-back, which opens a window in which a snoop can hit the buffered victim. A behavioural model of line states, memory and the expected order of bus transactions predicts every command, address, data block and intervention.

// File: rtl/cache_pkg.sv
package cache_pkg;

  typedef enum logic [1:0] {
    LINE_I = 2'd0,
    LINE_S = 2'd1,
    LINE_E = 2'd2
  } lineState_t;

  typedef enum logic [1:0] {
    CMD_NONE   = 2'd0,
    CMD_RDMISS = 2'd1,
    CMD_WRMISS = 2'd2,
    CMD_WB     = 2'd3
  } busCmd_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MISS = 2'd1,
    ST_WB   = 2'd2
  } ctrlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic acceptHit;
    logic startMiss;
    logic fillLine;
    logic wbDone;
    logic addrWb;
  } ctrlStrobe_t;

endpackage

// File: rtl/snoop_cache_dp.sv
module snoop_cache_dp
  import cache_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                cpuWrite,
  input  logic [ADDR_W-1:0]                   cpuAddr,
  input  logic [DATA_W-1:0]                   cpuWdata,
  input  logic                                snpValid,
  input  logic [1:0]                          snpCmd,
  input  logic [ADDR_W-$clog2(WORDS)-1:0]     snpAddr,
  input  logic [WORDS*DATA_W-1:0]             busRdata,
  input  ctrlStrobe_t                         strb,
  output logic                                cpuHit,
  output logic                                wbValid,
  output logic                                reqWrite,
  output logic [DATA_W-1:0]                   cpuRdata,
  output logic [ADDR_W-$clog2(WORDS)-1:0]     busAddr,
  output logic [WORDS*DATA_W-1:0]             busWdata,
  output logic                                intvValid,
  output logic [WORDS*DATA_W-1:0]             intvData
);

  localparam int OFF_W  = $clog2(WORDS);
  localparam int IDX_W  = $clog2(LINES);
  localparam int BLK_W  = ADDR_W - OFF_W;
  localparam int TAG_W  = BLK_W - IDX_W;
  localparam int LINE_W = WORDS * DATA_W;

  lineState_t         stArr   [LINES];
  logic [TAG_W-1:0]   tagArr  [LINES];
  logic [LINE_W-1:0]  dataArr [LINES];

  logic [ADDR_W-1:0]  reqAddr;
  logic [DATA_W-1:0]  reqWdata;
  logic [BLK_W-1:0]   wbBlk;
  logic [LINE_W-1:0]  wbData;

  // processor-side lookup
  logic [IDX_W-1:0] cIdx;
  logic [TAG_W-1:0] cTag;
  logic [OFF_W-1:0] cOff;
  logic             vicDirty;

  assign cIdx = cpuAddr[OFF_W +: IDX_W];
  assign cTag = cpuAddr[ADDR_W-1 -: TAG_W];
  assign cOff = cpuAddr[OFF_W-1:0];

  always_comb begin
    cpuHit = 1'b0;
    if (tagArr[cIdx] == cTag) begin
      if (stArr[cIdx] == LINE_E) cpuHit = 1'b1;
      else if (stArr[cIdx] == LINE_S && !cpuWrite) cpuHit = 1'b1;
    end
  end

  assign vicDirty = (stArr[cIdx] == LINE_E) && (tagArr[cIdx] != cTag);

  // latched miss request
  logic [IDX_W-1:0]  rIdx;
  logic [TAG_W-1:0]  rTag;
  logic [OFF_W-1:0]  rOff;
  logic [LINE_W-1:0] fillBlk;

  assign rIdx = reqAddr[OFF_W +: IDX_W];
  assign rTag = reqAddr[ADDR_W-1 -: TAG_W];
  assign rOff = reqAddr[OFF_W-1:0];

  always_comb begin
    fillBlk = busRdata;
    if (reqWrite) fillBlk[rOff*DATA_W +: DATA_W] = reqWdata;
  end

  // snoop side
  logic [IDX_W-1:0] sIdx;
  logic [TAG_W-1:0] sTag;
  logic             snpMiss;
  logic             lineMatch;
  logic             bufMatch;

  assign sIdx      = snpAddr[IDX_W-1:0];
  assign sTag      = snpAddr[BLK_W-1 -: TAG_W];
  assign snpMiss   = snpValid && (snpCmd == CMD_RDMISS || snpCmd == CMD_WRMISS);
  assign lineMatch = snpMiss && (stArr[sIdx] != LINE_I) && (tagArr[sIdx] == sTag);
  assign bufMatch  = snpMiss && wbValid && (wbBlk == snpAddr);

  assign intvValid = (lineMatch && stArr[sIdx] == LINE_E) || bufMatch;
  assign intvData  = bufMatch ? wbData : dataArr[sIdx];

  assign busAddr  = strb.addrWb ? wbBlk : reqAddr[ADDR_W-1:OFF_W];
  assign busWdata = wbData;

  // line states and buffer valid
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < LINES; i++) stArr[i] <= LINE_I;
      wbValid <= 1'b0;
    end else begin
      if (strb.startMiss && vicDirty) begin
        stArr[cIdx] <= LINE_I;
        wbValid     <= 1'b1;
      end
      if (strb.fillLine) begin
        stArr[rIdx] <= reqWrite ? LINE_E : LINE_S;
      end else if (lineMatch) begin
        if (snpCmd == CMD_WRMISS)          stArr[sIdx] <= LINE_I;
        else if (stArr[sIdx] == LINE_E)    stArr[sIdx] <= LINE_S;
      end
      if (bufMatch || strb.wbDone) wbValid <= 1'b0;
    end
  end

  // tags, data, request latch, result word
  always_ff @(posedge clk) begin
    if (strb.startMiss) begin
      reqAddr  <= cpuAddr;
      reqWrite <= cpuWrite;
      reqWdata <= cpuWdata;
      if (vicDirty) begin
        wbBlk  <= {tagArr[cIdx], cIdx};
        wbData <= dataArr[cIdx];
      end
    end
    if (strb.acceptHit) begin
      if (cpuWrite) begin
        dataArr[cIdx][cOff*DATA_W +: DATA_W] <= cpuWdata;
        cpuRdata <= cpuWdata;
      end else begin
        cpuRdata <= dataArr[cIdx][cOff*DATA_W +: DATA_W];
      end
    end
    if (strb.fillLine) begin
      dataArr[rIdx] <= fillBlk;
      tagArr[rIdx]  <= rTag;
      cpuRdata      <= fillBlk[rOff*DATA_W +: DATA_W];
    end
  end

  AST_SNOOP_WR_INVAL: assert property (@(posedge clk) disable iff (!rstN)
    (lineMatch && snpCmd == CMD_WRMISS && !strb.fillLine) |=> stArr[$past(sIdx)] == LINE_I); // R5
  AST_SNOOP_RD_DOWNGRADE: assert property (@(posedge clk) disable iff (!rstN)
    (lineMatch && snpCmd == CMD_RDMISS && stArr[sIdx] == LINE_E && !strb.fillLine)
      |=> stArr[$past(sIdx)] == LINE_S); // R6
  AST_WRITE_FILL_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fillLine && reqWrite) |=> stArr[$past(rIdx)] == LINE_E); // R3
  AST_BUF_HIT_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    bufMatch |=> !wbValid); // R9

endmodule

// File: rtl/snoop_cache_ctrl.sv
module snoop_cache_ctrl
  import cache_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpuReq,
  input  logic        snpValid,
  input  logic        busGnt,
  input  logic        busAck,
  input  logic        cpuHit,
  input  logic        wbValid,
  input  logic        reqWrite,
  output logic        cpuReady,
  output logic        cpuDone,
  output logic        busReq,
  output logic [1:0]  busCmd,
  output ctrlStrobe_t strb
);

  ctrlState_t state, stateNxt;

  always_comb begin
    stateNxt = state;
    cpuReady = 1'b0;
    busReq   = 1'b0;
    busCmd   = CMD_NONE;
    strb     = '0;
    unique case (state)
      ST_IDLE: begin
        cpuReady = !snpValid;
        if (cpuReq && !snpValid) begin
          if (cpuHit) begin
            strb.acceptHit = 1'b1;
          end else begin
            strb.startMiss = 1'b1;
            stateNxt       = ST_MISS;
          end
        end
      end
      ST_MISS: begin
        busReq = 1'b1;
        if (busGnt) busCmd = reqWrite ? CMD_WRMISS : CMD_RDMISS;
        if (busGnt && busAck) begin
          strb.fillLine = 1'b1;
          stateNxt      = wbValid ? ST_WB : ST_IDLE;
        end
      end
      ST_WB: begin
        strb.addrWb = 1'b1;
        if (!wbValid) begin
          stateNxt = ST_IDLE;
        end else begin
          busReq = 1'b1;
          if (busGnt) busCmd = CMD_WB;
          if (busGnt && busAck) begin
            strb.wbDone = 1'b1;
            stateNxt    = ST_IDLE;
          end
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cpuDone <= 1'b0;
    end else begin
      state   <= stateNxt;
      cpuDone <= strb.acceptHit | strb.fillLine;
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busAck && !snpValid) |=> busReq); // R11
  AST_WB_NEEDS_BUF: assert property (@(posedge clk) disable iff (!rstN)
    (busCmd == CMD_WB) |-> wbValid); // R8
  AST_HIT_LOCAL: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReq && cpuReady && cpuHit) |=> (cpuDone && !busReq)); // R4
  AST_SNOOP_BLOCKS_CPU: assert property (@(posedge clk) disable iff (!rstN)
    (snpValid && cpuReq) |=> !cpuDone || $past(state) != ST_IDLE || $past(cpuDone)); // R10

endmodule

// File: rtl/snoop_cache.sv
module snoop_cache
  import cache_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             cpuReq,
  input  logic                             cpuWrite,
  input  logic [ADDR_W-1:0]                cpuAddr,
  input  logic [DATA_W-1:0]                cpuWdata,
  output logic                             cpuReady,
  output logic                             cpuDone,
  output logic [DATA_W-1:0]                cpuRdata,
  output logic                             busReq,
  input  logic                             busGnt,
  output logic [1:0]                       busCmd,
  output logic [ADDR_W-$clog2(WORDS)-1:0]  busAddr,
  output logic [WORDS*DATA_W-1:0]          busWdata,
  input  logic                             busAck,
  input  logic [WORDS*DATA_W-1:0]          busRdata,
  input  logic                             snpValid,
  input  logic [1:0]                       snpCmd,
  input  logic [ADDR_W-$clog2(WORDS)-1:0]  snpAddr,
  output logic                             intvValid,
  output logic [WORDS*DATA_W-1:0]          intvData,
  output logic                             memAbort
);

  ctrlStrobe_t strb;
  logic        cpuHit;
  logic        wbValid;
  logic        reqWrite;

  snoop_cache_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cpuReq   (cpuReq),
    .snpValid (snpValid),
    .busGnt   (busGnt),
    .busAck   (busAck),
    .cpuHit   (cpuHit),
    .wbValid  (wbValid),
    .reqWrite (reqWrite),
    .cpuReady (cpuReady),
    .cpuDone  (cpuDone),
    .busReq   (busReq),
    .busCmd   (busCmd),
    .strb     (strb)
  );

  snoop_cache_dp #(
    .LINES (LINES),
    .WORDS (WORDS),
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cpuWrite  (cpuWrite),
    .cpuAddr   (cpuAddr),
    .cpuWdata  (cpuWdata),
    .snpValid  (snpValid),
    .snpCmd    (snpCmd),
    .snpAddr   (snpAddr),
    .busRdata  (busRdata),
    .strb      (strb),
    .cpuHit    (cpuHit),
    .wbValid   (wbValid),
    .reqWrite  (reqWrite),
    .cpuRdata  (cpuRdata),
    .busAddr   (busAddr),
    .busWdata  (busWdata),
    .intvValid (intvValid),
    .intvData  (intvData)
  );

  // a supplied dirty block always replaces the memory response
  assign memAbort = intvValid;

  AST_CMD_NEEDS_GNT: assert property (@(posedge clk) disable iff (!rstN)
    (busCmd != CMD_NONE) |-> busGnt); // R11
  AST_INTV_ONLY_ON_MISS: assert property (@(posedge clk) disable iff (!rstN)
    intvValid |-> (snpValid && snpCmd != CMD_WB && snpCmd != CMD_NONE)); // R5

endmodule

// File: tb/snoop_cache_bench.sv
module snoop_cache_bench;

  localparam int LINES = 8;
  localparam int WORDS = 4;
  localparam int DW    = 32;
  localparam int AW    = 32;
  localparam int BW    = AW - 2;
  localparam int LW    = WORDS * DW;

  logic          clk, rstN;
  logic          cpuReq, cpuWrite;
  logic [AW-1:0] cpuAddr;
  logic [DW-1:0] cpuWdata;
  logic          cpuReady, cpuDone;
  logic [DW-1:0] cpuRdata;
  logic          busReq, busGnt, busAck;
  logic [1:0]    busCmd;
  logic [BW-1:0] busAddr;
  logic [LW-1:0] busWdata, busRdata;
  logic          snpValid;
  logic [1:0]    snpCmd;
  logic [BW-1:0] snpAddr;
  logic          intvValid, memAbort;
  logic [LW-1:0] intvData;

  snoop_cache #(.LINES(LINES), .WORDS(WORDS), .DATA_W(DW), .ADDR_W(AW)) u_snoop_cache (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWrite(cpuWrite), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuReady(cpuReady), .cpuDone(cpuDone), .cpuRdata(cpuRdata),
    .busReq(busReq), .busGnt(busGnt), .busCmd(busCmd), .busAddr(busAddr),
    .busWdata(busWdata), .busAck(busAck), .busRdata(busRdata), .snpValid(snpValid),
    .snpCmd(snpCmd), .snpAddr(snpAddr), .intvValid(intvValid), .intvData(intvData),
    .memAbort(memAbort)
  );

  initial begin
    clk = 1'b0;
    forever #5 clk = ~clk;
  end

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [LW-1:0] act, input logic [LW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int            mSt  [LINES];   // 0 Invalid, 1 Shared, 2 Exclusive
  int            mTag [LINES];
  logic [LW-1:0] mLine[LINES];
  bit            mWbValid;
  int            mWbBlk;
  logic [DW-1:0] memArr[int];
  int            qCmd[$];
  int            qBlk[$];
  logic [LW-1:0] qData[$];
  bit            holdWb;

  function automatic logic [DW-1:0] memWord(int blk, int w);
    int k = blk * WORDS + w;
    if (memArr.exists(k)) return memArr[k];
    return 32'h5A00_0000 ^ (blk * 16 + w);
  endfunction

  function automatic logic [LW-1:0] memBlock(int blk);
    logic [LW-1:0] b;
    for (int w = 0; w < WORDS; w++) b[w*DW +: DW] = memWord(blk, w);
    return b;
  endfunction

  task automatic memStore(int blk, logic [LW-1:0] b);
    for (int w = 0; w < WORDS; w++) memArr[blk * WORDS + w] = b[w*DW +: DW];
  endtask

  // one bus-side step at a negedge: arbiter and memory
  task automatic serve();
    if (busGnt) begin
      busGnt = 1'b0;
      busAck = 1'b0;
    end else if (busReq) begin
      if (qCmd.size() == 0) begin
        chk(1'b0, "R4 no bus traffic expected", {126'b0, busCmd}, 0);
      end else if (!(holdWb && qCmd[0] == 3)) begin
        busGnt = 1'b1;
        #1;
        chk(busCmd == 2'(qCmd[0]), "R2 R3 R8 R11 bus command", {126'b0, busCmd}, qCmd[0]);
        chk(busAddr == BW'(qBlk[0]), "R2 R8 bus block address", busAddr, qBlk[0]);
        if (qCmd[0] == 3) begin
          chk(busWdata == qData[0], "R8 write-back data", busWdata, qData[0]);
          memStore(qBlk[0], busWdata);
        end else begin
          busRdata = memBlock(int'(busAddr));
        end
        void'(qCmd.pop_front());
        void'(qBlk.pop_front());
        void'(qData.pop_front());
        busAck = 1'b1;
      end
    end
  endtask

  task automatic doOp(input bit wr, input int addr, input logic [DW-1:0] wd, input string rq);
    int blk = addr >> 2;
    int off = addr & 3;
    int idx = blk & (LINES - 1);
    int tg  = blk >> 3;
    bit hit;
    bit done = 0;
    logic [DW-1:0] expR;
    logic [LW-1:0] fb;
    hit = (mSt[idx] == 2 || (mSt[idx] == 1 && !wr)) && mTag[idx] == tg;
    if (hit) begin
      expR = wr ? wd : mLine[idx][off*DW +: DW];
      if (wr) mLine[idx][off*DW +: DW] = wd;
    end else begin
      bit vic = (mSt[idx] == 2) && (mTag[idx] != tg);
      int vBlk = (mTag[idx] << 3) | idx;
      logic [LW-1:0] vData = mLine[idx];
      qCmd.push_back(wr ? 2 : 1); qBlk.push_back(blk); qData.push_back('0);
      if (vic) begin
        qCmd.push_back(3); qBlk.push_back(vBlk); qData.push_back(vData);
        mWbValid = 1; mWbBlk = vBlk;
      end
      fb = memBlock(blk);
      if (wr) fb[off*DW +: DW] = wd;
      mLine[idx] = fb; mSt[idx] = wr ? 2 : 1; mTag[idx] = tg;
      expR = fb[off*DW +: DW];
    end
    for (int c = 0; c < 50 && !cpuReady; c++) @(negedge clk);
    cpuReq = 1'b1; cpuWrite = wr; cpuAddr = AW'(addr); cpuWdata = wd;
    @(negedge clk);
    cpuReq = 1'b0;
    if (hit) chk(cpuDone && !busReq, {rq, " R4 hit local"}, {126'b0, cpuDone, busReq}, 2);
    else     chk(busReq && !cpuDone, {rq, " R11 miss requests bus"}, {126'b0, cpuDone, busReq}, 1);
    for (int c = 0; c < 60; c++) begin
      if (cpuDone) begin
        chk(cpuRdata == expR, {rq, " result word"}, cpuRdata, expR);
        done = 1;
      end
      serve();
      if (done && !busGnt && (qCmd.size() == 0 || (holdWb && qCmd[0] == 3))) break;
      @(negedge clk);
    end
    chk(done, {rq, " R4 completion seen"}, done, 1);
  endtask

  task automatic drain();
    for (int c = 0; c < 60; c++) begin
      if (qCmd.size() == 0 && cpuReady && !busGnt) break;
      serve();
      @(negedge clk);
    end
  endtask

  task automatic snoop(input int cmd, input int blk, input string rq);
    int idx = blk & (LINES - 1);
    int tg  = blk >> 3;
    bit lineE, bufHit, expIntv, isMiss;
    logic [LW-1:0] expD;
    isMiss = (cmd == 1 || cmd == 2);
    lineE  = mSt[idx] == 2 && mTag[idx] == tg;
    bufHit = mWbValid && mWbBlk == blk;
    expIntv = isMiss && (lineE || bufHit);
    expD = bufHit ? qData[qData.size()-1] : mLine[idx];
    snpValid = 1'b1; snpCmd = 2'(cmd); snpAddr = BW'(blk);
    #1;
    chk(intvValid == expIntv, {rq, " intervention flag"}, intvValid, expIntv);
    chk(memAbort == expIntv, {rq, " memory abort"}, memAbort, expIntv);
    chk(!cpuReady, "R10 ready low while snooping", cpuReady, 0);
    if (expIntv) begin
      chk(intvData == expD, {rq, " intervention block"}, intvData, expD);
      memStore(blk, expD);
    end
    if (isMiss && mSt[idx] != 0 && mTag[idx] == tg) begin
      if (cmd == 2) mSt[idx] = 0;
      else if (mSt[idx] == 2) mSt[idx] = 1;
    end
    if (isMiss && bufHit) begin
      mWbValid = 0;
      void'(qCmd.pop_back()); void'(qBlk.pop_back()); void'(qData.pop_back());
    end
    @(negedge clk);
    snpValid = 1'b0; snpCmd = 2'd0;
  endtask

  initial begin
    rstN = 1'b0; cpuReq = 1'b0; cpuWrite = 1'b0; cpuAddr = '0; cpuWdata = '0;
    busGnt = 1'b0; busAck = 1'b0; busRdata = '0;
    snpValid = 1'b0; snpCmd = 2'd0; snpAddr = '0; holdWb = 0; mWbValid = 0;
    for (int i = 0; i < LINES; i++) begin mSt[i] = 0; mTag[i] = 0; mLine[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cpuReady && !cpuDone && !busReq && !intvValid, "R1 reset outputs",
        {124'b0, cpuReady, cpuDone, busReq, intvValid}, 8);

    doOp(0, 32'h100, 0, "R1 R2 cold read miss");
    doOp(0, 32'h101, 0, "R4 read hit shared");
    snoop(1, 32'h40, "R2 shared gives no intervention");
    doOp(1, 32'h102, 32'hDEAD0002, "R3 write to shared is a miss");
    doOp(0, 32'h102, 0, "R3 merged word");
    doOp(0, 32'h103, 0, "R3 fetched neighbour word");
    doOp(1, 32'h103, 32'hBEEF0003, "R4 write hit exclusive");
    snoop(3, 32'h40, "R5 snooped write-back ignored");
    doOp(0, 32'h103, 0, "R5 line still exclusive");
    snoop(1, 32'h40, "R6 read miss to exclusive");
    doOp(1, 32'h100, 32'h11110000, "R3 R6 write after downgrade");
    snoop(2, 32'h40, "R7 write miss to exclusive");
    doOp(0, 32'h100, 0, "R7 refetch after invalidation");
    snoop(2, 32'h40, "R5 write miss to shared");
    doOp(0, 32'h103, 0, "R5 refetch after invalidation");

    // dirty victim in index 1
    doOp(1, 32'h204, 32'hCAFE0004, "R3 write miss fills");
    doOp(0, 32'h404, 0, "R8 miss then victim write-back");
    doOp(0, 32'h204, 0, "R8 written-back data returns");

    // buffered victim in index 2, write-back held back
    doOp(1, 32'h209, 32'hF00D0009, "R3 write miss fills");
    holdWb = 1;
    doOp(1, 32'h408, 32'h0BAD0008, "R8 miss before held write-back");
    snoop(1, 32'h82, "R9 snoop answered from buffer");
    holdWb = 0;
    drain();
    chk(cpuReady && !busReq, "R9 write-back dropped", {126'b0, cpuReady, busReq}, 2);
    doOp(0, 32'h209, 0, "R9 R8 intervened data in memory");
    drain();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule